// File: doc/BRIEF.md
# Two-Level Transmit Interrupt Status Unit

This block gathers interrupt events from a ten-queue transmit engine and reports them to a host. Each event sets a sticky bit in one of five secondary status registers. A single primary register shows summary bits. Each summary bit is the live OR of a group of secondary bits, so the host can see in one read which kind of event is pending. It then reads the matching secondary register to find out which queue raised it.

The host reaches all registers through a simple register port. The port has a write strobe, a read strobe and separate read and write addresses. A write clears exactly the status bits that are written as one. A mask register selects which primary bits drive the single level-sensitive interrupt line. One primary bit, "no frame sent", has no per-queue status. A per-queue enable register gates it, and it is held directly in the primary register.

Top module: `irq_status_agg`

## Requirements
- R1: A one-cycle pulse on a per-queue event input sets the sticky bit for that queue in its secondary register, one clock edge later. The per-queue fields are placed as follows:
  - Address 1 holds transmit-OK at bits 0..9 and descriptor-request at bits 16..25.
  - Address 2 holds transmit-error at bits 0..9 and end-of-list at bits 16..25.
  - Address 3 holds underrun at bits 0..9.
  - Address 4 holds rate-overrun at bits 0..9 and rate-underrun at bits 16..25.
  - Address 5 holds queue-trigger at bits 0..9.
- R2: Primary (address 0) bit 6 is the OR of the transmit-OK field, and bit 7 is the OR of the descriptor field. Bit 8 is the OR of the transmit-error field, bit 10 the OR of the end-of-list field, and bit 11 the OR of the underrun field.
- R3: Address 3 bits 16..18 hold the host-bus events: master abort, system error and parity error. Primary bit 19 is their OR. Address 3 bits 19..24 hold six beacon events, and primary bit 23 is their OR.
- R4: Primary bit 25 is the OR of the rate-overrun field, bit 26 the OR of the rate-underrun field, and bit 27 the OR of the queue-trigger field.
- R5: Primary bit 9 is set by a no-frame event on queue q only when bit q of the queue-enable register (address 7) is one. An event on a disabled queue leaves bit 9 clear.
- R6: A register write clears each status bit written with one. Bits written with zero stay as they were.
- R7: If an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: Primary summary bits are derived live. Clearing every contributing secondary bit clears the summary bit. Writing ones to primary bits other than bit 9 has no effect.
- R9: `irq_o` is registered. It equals the OR of (primary AND mask register at address 6) as it stood one cycle earlier.
- R10: A read returns data on `rd_data_o` one cycle after the read strobe. After reset, every register reads zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_txok_i | input | NQ | Per-queue transmit-OK event pulses |
| ev_txdesc_i | input | NQ | Per-queue descriptor-request event pulses |
| ev_txerr_i | input | NQ | Per-queue transmit-error event pulses |
| ev_txeol_i | input | NQ | Per-queue end-of-list event pulses |
| ev_txurn_i | input | NQ | Per-queue FIFO-underrun event pulses |
| ev_nofrm_i | input | NQ | Per-queue no-frame-sent event pulses |
| ev_hosterr_i | input | 3 | Master abort, system error, parity error |
| ev_bcn_i | input | 6 | Six beacon-related event pulses |
| ev_cbrovr_i | input | NQ | Per-queue rate-overrun event pulses |
| ev_cbrurn_i | input | NQ | Per-queue rate-underrun event pulses |
| ev_qtrig_i | input | NQ | Per-queue trigger event pulses |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | DW | Write data (ones clear status bits) |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | DW | Registered read data |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
The assertions assume that reset is applied for at least one cycle before any check matters. They also assume that event inputs are plain synchronous levels sampled at the clock edge, so a pulse held across several edges just sets the bit again. The stimulus changes every input only at falling edges. It raises one event at a time from a cleared state, so each expected register value is a single known bit. The deliberate overlap of an event with a clearing write on the same bit is applied inside a single cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int AW       = 3;
  localparam int NSEC     = 5;
  // per-queue field offsets inside a secondary register
  localparam int OFS_LO   = 0;
  localparam int OFS_HI   = 16;
  // secondary register 2: host-bus and beacon event positions
  localparam int OFS_HERR = 16;
  localparam int N_HERR   = 3;
  localparam int OFS_BCN  = 19;
  localparam int N_BCN    = 6;
  // primary summary bit positions
  localparam int P_TXOK   = 6;
  localparam int P_TXDESC = 7;
  localparam int P_TXERR  = 8;
  localparam int P_NOFRM  = 9;
  localparam int P_TXEOL  = 10;
  localparam int P_TXURN  = 11;
  localparam int P_HERR   = 19;
  localparam int P_BCN    = 23;
  localparam int P_CBROVR = 25;
  localparam int P_CBRURN = 26;
  localparam int P_QTRIG  = 27;
  // register addresses
  localparam logic [AW-1:0] A_PRIM = 3'd0;
  localparam logic [AW-1:0] A_SEC0 = 3'd1;
  localparam logic [AW-1:0] A_MASK = 3'd6;
  localparam logic [AW-1:0] A_QEN  = 3'd7;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  // event has priority over write-one-to-clear
  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= (q_r & ~clr_i) | set_i;
  end

  assign q_o = q_r;

  p_event_wins_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q_o & $past(set_i)) == $past(set_i)));

  p_zero_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q_o & ~$past(set_i | clr_i)) == ($past(q_o) & ~$past(set_i | clr_i))));

  p_one_clears_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_agg_pkg::*;
#(
  parameter int NQ = 10,
  parameter int DW = 32
) (
  input  logic [NQ-1:0]     txok_i,
  input  logic [NQ-1:0]     txdesc_i,
  input  logic [NQ-1:0]     txerr_i,
  input  logic [NQ-1:0]     txeol_i,
  input  logic [NQ-1:0]     txurn_i,
  input  logic [N_HERR-1:0] herr_i,
  input  logic [N_BCN-1:0]  bcn_i,
  input  logic [NQ-1:0]     cbrovr_i,
  input  logic [NQ-1:0]     cbrurn_i,
  input  logic [NQ-1:0]     qtrig_i,
  input  logic              nofrm_i,
  output logic [DW-1:0]     prim_o
);
  always_comb begin
    prim_o           = '0;
    prim_o[P_TXOK]   = |txok_i;
    prim_o[P_TXDESC] = |txdesc_i;
    prim_o[P_TXERR]  = |txerr_i;
    prim_o[P_NOFRM]  = nofrm_i;
    prim_o[P_TXEOL]  = |txeol_i;
    prim_o[P_TXURN]  = |txurn_i;
    prim_o[P_HERR]   = |herr_i;
    prim_o[P_BCN]    = |bcn_i;
    prim_o[P_CBROVR] = |cbrovr_i;
    prim_o[P_CBRURN] = |cbrurn_i;
    prim_o[P_QTRIG]  = |qtrig_i;
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int NQ = 10,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NQ-1:0]     ev_txok_i,
  input  logic [NQ-1:0]     ev_txdesc_i,
  input  logic [NQ-1:0]     ev_txerr_i,
  input  logic [NQ-1:0]     ev_txeol_i,
  input  logic [NQ-1:0]     ev_txurn_i,
  input  logic [NQ-1:0]     ev_nofrm_i,
  input  logic [N_HERR-1:0] ev_hosterr_i,
  input  logic [N_BCN-1:0]  ev_bcn_i,
  input  logic [NQ-1:0]     ev_cbrovr_i,
  input  logic [NQ-1:0]     ev_cbrurn_i,
  input  logic [NQ-1:0]     ev_qtrig_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              irq_o
);
  logic [NSEC-1:0][DW-1:0] sec_set, sec_clr, sec_q;
  logic [DW-1:0] prim, mask_r, rd_r;
  logic [NQ-1:0] qen_r;
  logic          nofrm_set, nofrm_clr, nofrm_q, irq_r;

  // route event inputs onto their secondary positions
  always_comb begin
    sec_set = '0;
    sec_set[0][OFS_LO +: NQ]       = ev_txok_i;
    sec_set[0][OFS_HI +: NQ]       = ev_txdesc_i;
    sec_set[1][OFS_LO +: NQ]       = ev_txerr_i;
    sec_set[1][OFS_HI +: NQ]       = ev_txeol_i;
    sec_set[2][OFS_LO +: NQ]       = ev_txurn_i;
    sec_set[2][OFS_HERR +: N_HERR] = ev_hosterr_i;
    sec_set[2][OFS_BCN +: N_BCN]   = ev_bcn_i;
    sec_set[3][OFS_LO +: NQ]       = ev_cbrovr_i;
    sec_set[3][OFS_HI +: NQ]       = ev_cbrurn_i;
    sec_set[4][OFS_LO +: NQ]       = ev_qtrig_i;
  end

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    assign sec_clr[g] = (wr_en_i && (wr_addr_i == A_SEC0 + AW'(g))) ? wr_data_i : '0;
    irq_sticky_bank #(.W(DW)) i_bank (
      .clk  (clk),
      .rst  (rst),
      .set_i(sec_set[g]),
      .clr_i(sec_clr[g]),
      .q_o  (sec_q[g])
    );
  end

  // no-frame bit lives directly in the primary register
  assign nofrm_set = |(ev_nofrm_i & qen_r);
  assign nofrm_clr = wr_en_i && (wr_addr_i == A_PRIM) && wr_data_i[P_NOFRM];

  irq_sticky_bank #(.W(1)) i_nofrm (
    .clk  (clk),
    .rst  (rst),
    .set_i(nofrm_set),
    .clr_i(nofrm_clr),
    .q_o  (nofrm_q)
  );

  irq_summary #(.NQ(NQ), .DW(DW)) i_sum (
    .txok_i  (sec_q[0][OFS_LO +: NQ]),
    .txdesc_i(sec_q[0][OFS_HI +: NQ]),
    .txerr_i (sec_q[1][OFS_LO +: NQ]),
    .txeol_i (sec_q[1][OFS_HI +: NQ]),
    .txurn_i (sec_q[2][OFS_LO +: NQ]),
    .herr_i  (sec_q[2][OFS_HERR +: N_HERR]),
    .bcn_i   (sec_q[2][OFS_BCN +: N_BCN]),
    .cbrovr_i(sec_q[3][OFS_LO +: NQ]),
    .cbrurn_i(sec_q[3][OFS_HI +: NQ]),
    .qtrig_i (sec_q[4][OFS_LO +: NQ]),
    .nofrm_i (nofrm_q),
    .prim_o  (prim)
  );

  // control registers and registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_r <= '0;
      qen_r  <= '0;
      rd_r   <= '0;
      irq_r  <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == A_MASK) mask_r <= wr_data_i;
      if (wr_en_i && wr_addr_i == A_QEN)  qen_r  <= wr_data_i[NQ-1:0];
      irq_r <= |(prim & mask_r);
      if (rd_en_i) begin
        case (rd_addr_i)
          A_PRIM:  rd_r <= prim;
          A_MASK:  rd_r <= mask_r;
          A_QEN:   rd_r <= DW'(qen_r);
          default: rd_r <= sec_q[rd_addr_i - A_SEC0];
        endcase
      end
    end
  end

  assign rd_data_o = rd_r;
  assign irq_o     = irq_r;

  p_irq_level_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == (|($past(prim) & $past(mask_r)))));

  p_nofrm_gated_r5: assert property (@(posedge clk) disable iff (rst)
    (!nofrm_q && ((ev_nofrm_i & qen_r) == '0)) |=> !prim[P_NOFRM]);
endmodule

// File: tb/test_irq_status_agg.sv
module test_irq_status_agg;
  localparam int CLK_NS = 10;
  localparam int NQ = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NQ-1:0] ev_txok = '0, ev_txdesc = '0, ev_txerr = '0, ev_txeol = '0, ev_txurn = '0;
  logic [NQ-1:0] ev_nofrm = '0, ev_cbrovr = '0, ev_cbrurn = '0, ev_qtrig = '0;
  logic [2:0] ev_herr = '0;
  logic [5:0] ev_bcn = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  irq_status_agg #(.NQ(NQ), .DW(DW)) i_irq_status_agg (
    .clk(clk), .rst(rst),
    .ev_txok_i(ev_txok), .ev_txdesc_i(ev_txdesc), .ev_txerr_i(ev_txerr),
    .ev_txeol_i(ev_txeol), .ev_txurn_i(ev_txurn), .ev_nofrm_i(ev_nofrm),
    .ev_hosterr_i(ev_herr), .ev_bcn_i(ev_bcn), .ev_cbrovr_i(ev_cbrovr),
    .ev_cbrurn_i(ev_cbrurn), .ev_qtrig_i(ev_qtrig),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  // table: source code, queue/bit index, secondary address, secondary bit, primary bit
  // source codes: 0 txok 1 txdesc 2 txerr 3 txeol 4 txurn 5 hosterr 6 beacon 7 cbrovr 8 cbrurn 9 qtrig
  localparam int NV = 13;
  localparam int V_SRC [NV] = '{0, 0, 1, 2, 3, 4, 5, 5, 6, 6, 7, 8, 9};
  localparam int V_IDX [NV] = '{0, 9, 3, 5, 9, 2, 0, 2, 0, 5, 4, 7, 1};
  localparam int V_ADR [NV] = '{1, 1, 1, 2, 2, 3, 3, 3, 3, 3, 4, 4, 5};
  localparam int V_SBIT[NV] = '{0, 9, 19, 5, 25, 2, 16, 18, 19, 24, 4, 23, 1};
  localparam int V_PBIT[NV] = '{6, 6, 7, 8, 10, 11, 19, 19, 23, 23, 25, 26, 27};

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_src(input int src, input int idx, input logic v);
    case (src)
      0: ev_txok[idx] = v;
      1: ev_txdesc[idx] = v;
      2: ev_txerr[idx] = v;
      3: ev_txeol[idx] = v;
      4: ev_txurn[idx] = v;
      5: ev_herr[idx] = v;
      6: ev_bcn[idx] = v;
      7: ev_cbrovr[idx] = v;
      8: ev_cbrurn[idx] = v;
      9: ev_qtrig[idx] = v;
      default: ev_nofrm[idx] = v;
    endcase
  endtask

  task automatic pulse(input int src, input int idx);
    @(negedge clk); set_src(src, idx, 1'b1);
    @(negedge clk); set_src(src, idx, 1'b0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R10 reset read", d, '0);
    end
    chk("R10 reset irq", DW'(irq), '0);

    // R1..R4, R8: table walk
    for (int i = 0; i < NV; i++) begin
      pulse(V_SRC[i], V_IDX[i]);
      rd(3'(V_ADR[i]), d);
      chk("R1 secondary bit", d, DW'(1) << V_SBIT[i]);
      rd(3'd0, d);
      chk("R2/R3/R4 primary summary", d, DW'(1) << V_PBIT[i]);
      wr(3'(V_ADR[i]), DW'(1) << V_SBIT[i]);
      rd(3'd0, d);
      chk("R8 summary cleared", d, '0);
    end

    // R5: no-frame gated by queue enable
    pulse(10, 3);
    rd(3'd0, d);
    chk("R5 disabled queue", d, '0);
    wr(3'd7, 32'h0000_0008);
    rd(3'd7, d);
    chk("R5 enable readback", d, 32'h0000_0008);
    pulse(10, 3);
    rd(3'd0, d);
    chk("R5 enabled queue", d, 32'h0000_0200);
    wr(3'd0, 32'h0000_0000);
    rd(3'd0, d);
    chk("R6 zero write keeps bit9", d, 32'h0000_0200);
    wr(3'd0, 32'h0000_0200);
    rd(3'd0, d);
    chk("R6 one write clears bit9", d, '0);

    // R6: partial clear
    pulse(0, 1);
    pulse(0, 2);
    wr(3'd1, 32'h0000_0002);
    rd(3'd1, d);
    chk("R6 partial clear", d, 32'h0000_0004);

    // R8: primary writes to derived bits ignored
    wr(3'd0, 32'h0000_0040);
    rd(3'd0, d);
    chk("R8 derived bit unaffected", d, 32'h0000_0040);

    // R7: event and clear in the same cycle
    @(negedge clk);
    ev_txok[4] = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'h0000_0014;
    @(negedge clk);
    ev_txok[4] = 1'b0; wr_en = 1'b0;
    rd(3'd1, d);
    chk("R7 event wins", d, 32'h0000_0010);
    wr(3'd1, 32'h0000_0010);

    // R9: irq timing and masking
    wr(3'd6, 32'h0000_0800);
    @(negedge clk); ev_txurn[0] = 1'b1;
    @(negedge clk); ev_txurn[0] = 1'b0;
    chk("R9 irq one cycle late", DW'(irq), '0);
    @(negedge clk);
    chk("R9 irq asserted", DW'(irq), 32'h1);
    wr(3'd6, 32'h0000_0040);
    @(negedge clk);
    chk("R9 irq masked off", DW'(irq), '0);
    wr(3'd6, 32'h0000_0800);
    @(negedge clk);
    wr(3'd3, 32'h0000_0001);
    @(negedge clk);
    chk("R9 irq drops after clear", DW'(irq), '0);

    finish_run();
  end
endmodule